// File: doc/BRIEF.md
# Multi-Requester Hardware Lock Register

This block holds a byte of lock bits that several bus requesters share to take turns on common system resources. Each requester has its own plain register port: a write strobe, an address, write data and read data. The port's index is the requester's identity. To take a lock, a requester writes a one to the lock's bit and then reads the register. A one in that bit means it now holds the lock. To give the lock back, the holder writes a zero to the bit. Only the holder can free a bit.

Each lock bit is a small two-state machine. In state `LK_FREE` nobody owns the bit. In state `LK_HELD` the bit records the index of its owner. There are two transitions. `TAKE` goes from `LK_FREE` to `LK_HELD` when at least one requester writes a one to a free bit; the lowest-numbered of those requesters becomes the owner. `GIVE_BACK` goes from `LK_HELD` to `LK_FREE` when the owner writes a zero to the bit. All other write traffic leaves the state and the owner as they are.

The bits guard these resources: bit 0 the USB subsystem, bit 1 the Ethernet subsystem, bit 2 the UART subsystem, bit 3 the SMBus peripheral, bit 4 the SPI peripheral, bit 5 the general peripheral, and bit 7 the main lock. Bit 6 is not implemented. The register lives at offset 0xA0 of the system register region that starts at 0x4000, so its full address is 0x40A0.

Top module: `hw_lock_reg`

## Requirements
- R1: After reset every lock bit is in `LK_FREE`, and every requester reads 0x00 from 0x40A0.
- R2: Only an access to address 0x40A0 reaches the lock bits. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: A write of one to a bit in `LK_FREE` takes the bit (`TAKE`). From the next clock edge onward the writer reads a one in that bit position.
- R4: Read data from 0x40A0 shows a one only in the bits that the reading requester owns. Bits that are free or held by another requester read as zero, so no bit ever reads as one at two ports.
- R5: A write of one to a bit that another requester holds is ignored. The owner keeps the bit and the writer still reads zero there.
- R6: When several requesters write one to the same free bit in the same cycle, the requester with the lowest index wins and the others read zero.
- R7: A write of zero from the owner frees the bit (`GIVE_BACK`). The owner then reads zero there, and another requester can take the bit afterwards.
- R8: A write of zero to a bit from a requester that does not own it has no effect.
- R9: Bit 6 cannot be taken. It ignores every write and reads as zero at every port.
- R10: The lock bits act independently, so one write can take and free several bits at once. An owner that writes one to a bit it already holds keeps that bit.
- R11: When the owner frees a bit in the same cycle that another requester writes one to it, the bit ends up free. The claim is ignored because the bit was held when the write arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | NREQ | Write strobe, one bit per requester |
| req_addr | input | NREQ*AW | Address, one AW-bit slice per requester |
| req_wdata | input | NREQ*DW | Write data, one DW-bit slice per requester |
| req_rdata | output | NREQ*DW | Combinational read data, one DW-bit slice per requester |

## Verification
Two of the block's functions can fall in the same cycle. The first is two claims on one free bit in one cycle, where the priority pick decides the owner. The second is the owner freeing a bit in the same cycle that another requester tries to claim it. Directed cycles set up both cases on purpose: two requesters take a free bit together, and an owner writes zero while another port writes one. A long run of seeded random writes, mostly aimed at the lock address, produces many more of these collisions by chance. After every cycle, the bench compares each port's read data with a bench model of owners that is updated from the requirements, with the free-or-held state taken before the edge.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lk_state_e;

endpackage

// File: rtl/hw_lock_cell.sv
module hw_lock_cell
    import hw_lock_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int OW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] claim_req,
    input  logic [NREQ-1:0] drop_req,
    output logic            held,
    output logic [OW-1:0]   owner
);

    lk_state_e     state_q, state_d;
    logic [OW-1:0] owner_q, owner_d;
    logic [OW-1:0] pick;

    // fixed priority: lowest index wins
    always_comb begin
        pick = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (claim_req[i]) pick = OW'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            LK_FREE: begin
                if (|claim_req) begin        // TAKE
                    state_d = LK_HELD;
                    owner_d = pick;
                end
            end
            LK_HELD: begin
                if (drop_req[owner_q]) begin // GIVE_BACK
                    state_d = LK_FREE;
                    owner_d = '0;
                end
            end
            default: begin
                state_d = LK_FREE;
                owner_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        held  = (state_q == LK_HELD);
        owner = owner_q;
    end

    AST_OWNER_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        held && drop_req[owner] |=> !held); // R7

    AST_HOLD_AGAINST_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        held && !drop_req[owner] |=> held && $stable(owner)); // R5 R8 R11

    AST_FREE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !held && !(|claim_req) |=> !held); // R3

    AST_CLAIM_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !held && (|claim_req) |=> held
            && ((($past(claim_req)) >> owner) & NREQ'(1)) == NREQ'(1)
            && ($past(claim_req) & ((NREQ'(1) << owner) - NREQ'(1))) == '0); // R6

endmodule

// File: rtl/hw_lock_view.sv
module hw_lock_view #(
    parameter int NREQ = 4,
    parameter int DW   = 8,
    parameter int OW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [DW-1:0]      held_v,
    input  logic [DW*OW-1:0]   owner_flat,
    input  logic [NREQ-1:0]    hit,
    output logic [NREQ*DW-1:0] rdata
);

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        for (genvar b = 0; b < DW; b++) begin : g_bit
            assign rdata[i*DW + b] = hit[i] && held_v[b]
                                     && (owner_flat[b*OW +: OW] == OW'(i));
        end
    end

endmodule

// File: rtl/hw_lock_reg.sv
module hw_lock_reg #(
    parameter int              NREQ      = 4,
    parameter int              AW        = 16,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   REG_BASE  = 16'h4000,
    parameter logic [AW-1:0]   REG_OFS   = 16'h00A0,
    parameter logic [DW-1:0]   USED_MASK = 8'hBF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_wr,
    input  logic [NREQ*AW-1:0]   req_addr,
    input  logic [NREQ*DW-1:0]   req_wdata,
    output logic [NREQ*DW-1:0]   req_rdata
);

    localparam int            OW       = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam logic [AW-1:0] LOCK_ADR = REG_BASE + REG_OFS;

    logic [NREQ-1:0]  hit;
    logic [NREQ-1:0]  claim_m [DW];
    logic [NREQ-1:0]  drop_m  [DW];
    logic [DW-1:0]    held_v;
    logic [DW*OW-1:0] owner_flat;

    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            hit[i] = (req_addr[i*AW +: AW] == LOCK_ADR);
        end
        for (int b = 0; b < DW; b++) begin
            for (int i = 0; i < NREQ; i++) begin
                claim_m[b][i] = USED_MASK[b] && req_wr[i] && hit[i]
                                && req_wdata[i*DW + b];
                drop_m[b][i]  = req_wr[i] && hit[i] && !req_wdata[i*DW + b];
            end
        end
    end

    for (genvar b = 0; b < DW; b++) begin : g_lock
        hw_lock_cell #(.NREQ(NREQ), .OW(OW)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim_req (claim_m[b]),
            .drop_req  (drop_m[b]),
            .held      (held_v[b]),
            .owner     (owner_flat[b*OW +: OW])
        );
    end

    hw_lock_view #(.NREQ(NREQ), .DW(DW), .OW(OW)) u_view (
        .held_v     (held_v),
        .owner_flat (owner_flat),
        .hit        (hit),
        .rdata      (req_rdata)
    );

    for (genvar b = 0; b < DW; b++) begin : g_chk
        logic [NREQ-1:0] col;
        always_comb begin
            for (int i = 0; i < NREQ; i++) col[i] = req_rdata[i*DW + b];
        end

        AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) <= 1); // R4

        if (!USED_MASK[b]) begin : g_unused
            AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                col == '0); // R9
        end
    end

    AST_RESET_FREE: assert property (@(posedge clk)
        !rst_n |=> held_v == '0); // R1

endmodule

// File: tb/hw_lock_reg_bench.sv
`timescale 1ns/1ps
module hw_lock_reg_bench;

    localparam int NREQ = 4;
    localparam int AW   = 16;
    localparam int DW   = 8;
    localparam logic [AW-1:0] LOCK_ADR  = 16'h40A0;
    localparam logic [AW-1:0] OTHER_ADR = 16'h40A4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NREQ-1:0]    req_wr = '0;
    logic [NREQ*AW-1:0] req_addr = '0;
    logic [NREQ*DW-1:0] req_wdata = '0;
    logic [NREQ*DW-1:0] req_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    bit m_held [DW];
    int m_own  [DW];

    always #4 clk = ~clk;

    hw_lock_reg u_hw_lock_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_rdata (req_rdata)
    );

    function automatic logic [DW-1:0] exp_read(input int r);
        logic [DW-1:0] v = '0;
        for (int b = 0; b < DW; b++) v[b] = m_held[b] && (m_own[b] == r);
        return v;
    endfunction

    function automatic bit wr_hit(input int r);
        return req_wr[r] && (req_addr[r*AW +: AW] == LOCK_ADR);
    endfunction

    task automatic model_update();
        for (int b = 0; b < DW; b++) begin
            if (b == 6) continue;
            if (m_held[b]) begin
                if (wr_hit(m_own[b]) && !req_wdata[m_own[b]*DW + b]) m_held[b] = 0;
            end else begin
                for (int i = 0; i < NREQ; i++) begin
                    if (wr_hit(i) && req_wdata[i*DW + b]) begin
                        m_held[b] = 1;
                        m_own[b]  = i;
                        break;
                    end
                end
            end
        end
    endtask

    task automatic verify(input string tag);
        req_wr = '0;
        for (int i = 0; i < NREQ; i++) req_addr[i*AW +: AW] = LOCK_ADR;
        #1;
        for (int i = 0; i < NREQ; i++) begin
            n_checks++;
            if (req_rdata[i*DW +: DW] !== exp_read(i)) begin
                n_fail++;
                $display("FAIL %s req%0d rdata=%h expected %h", tag, i,
                         req_rdata[i*DW +: DW], exp_read(i));
            end
        end
        for (int i = 0; i < NREQ; i++) req_addr[i*AW +: AW] = OTHER_ADR;
        #1;
        for (int i = 0; i < NREQ; i++) begin
            n_checks++;
            if (req_rdata[i*DW +: DW] !== '0) begin
                n_fail++;
                $display("FAIL R2 req%0d rdata=%h expected 00", i, req_rdata[i*DW +: DW]);
            end
        end
    endtask

    task automatic put(input int r, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_wr[r] = 1'b1;
        req_addr[r*AW +: AW] = a;
        req_wdata[r*DW +: DW] = d;
    endtask

    task automatic tick(input string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        verify(tag);
    endtask

    initial begin
        for (int b = 0; b < DW; b++) begin m_held[b] = 0; m_own[b] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        verify("R1");

        put(1, LOCK_ADR, 8'h02);                  tick("R3");
        put(0, LOCK_ADR, 8'h02);                  tick("R5");
        put(0, LOCK_ADR, 8'h00);                  tick("R8");
        put(2, LOCK_ADR, 8'h81); put(3, LOCK_ADR, 8'h81); tick("R6");
        put(1, LOCK_ADR, 8'h00); put(3, LOCK_ADR, 8'h02); tick("R11");
        put(3, LOCK_ADR, 8'h02);                  tick("R7");
        put(0, LOCK_ADR, 8'hFF);                  tick("R9");
        put(2, 16'h4000, 8'h00);                  tick("R2");
        put(2, LOCK_ADR, 8'h81);                  tick("R10");
        put(0, LOCK_ADR, 8'h14); put(2, LOCK_ADR, 8'h01); tick("R10");

        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < NREQ; i++) begin
                req_wr[i] = $urandom_range(0, 1) == 1;
                req_addr[i*AW +: AW] = ($urandom_range(0, 3) == 0) ?
                                       AW'($urandom) : LOCK_ADR;
                req_wdata[i*DW +: DW] = DW'($urandom);
            end
            tick("R4");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule